// File: doc/BRIEF.md
# Configurable I/O cell logic

This block is a behavioural model of one programmable I/O cell in a field-programmable fabric. A static configuration word sets how the output path behaves. In one setting the path is a 2:1 selector, so two internal signals can take turns driving one pad. In the other it is a 2-input gate (pass, AND, OR or XOR), and each operand can be inverted before the gate is applied. The pad is driven either straight from this path or from an output register.

The cell also has an input capture register that samples the pad. Each of the two registers has its own clock, and each clock can be inverted to give falling-edge triggering. A shared early clock can stand in for either clock, or both. Each register also has its own clock enable. A global set/reset loads each register with its own configured initial value, and it takes priority over the clock enable. A pull/drive mode field and a high-impedance flag are plain logic outputs that go to the pad electronics.

The configuration word is loaded on the fabric clock while a valid strobe is high. It then holds until the next load.

Top module: `iocell_top`

## Requirements
- R1: A synchronous active-low reset on `clk` clears the configuration word to zero. This gives selector mode, pull mode 00 (pull-up), the pad driven from the combinational path, non-inverted clocks, no early-clock routing and initial values of 0.
- R2: The configuration word `cfg_word` is taken in on a rising edge of `clk` only while `cfg_valid` is high. While `cfg_valid` is low, a change on `cfg_word` has no effect. Bit layout: [0] gate mode (1) / selector mode (0); [2:1] gate function; [3] invert operand A (`d0`); [4] invert operand B (`d1`); [5] invert input-register clock; [6] invert output-register clock; [7] input-register initial value; [8] output-register initial value; [9] early clock drives the input register; [10] early clock drives the output register; [12:11] pull mode; [13] pad from the output register (1) or from the combinational path (0).
- R3: In selector mode the path output is `d1` when `sel` is 1 and `d0` when `sel` is 0. The inversion bits are not applied in this mode.
- R4: In gate mode the operands are A = `d0` XOR bit 3 and B = `d1` XOR bit 4. The path output is A for function 00, A AND B for 01, A OR B for 10, and A XOR B for 11.
- R5: When bit 13 is 1, `pad_o` shows the output register. On its active edge this register captures the path output if `oce` is 1, and holds its value if `oce` is 0.
- R6: On its active edge the input register captures `pad_i` into `in_q` if `ice` is 1, and holds its value if `ice` is 0.
- R7: A register whose clock-invert bit is 1 captures on the falling edge of its clock and ignores the rising edge. With the bit at 0 it captures on the rising edge only.
- R8: When a register's early-clock bit is 1, that register is clocked by `eclk`, and edges on its own clock (`ick` or `ock`) have no effect.
- R9: If `gsr` is 1 at a register's active edge, the register loads its initial-value bit, whatever its clock enable is.
- R10: When `oe_n` is 1, `pad_hiz` is 1 and `pad_o` is 0. When `oe_n` is 0, `pad_hiz` is 0 and `pad_o` carries the selected data.
- R11: `pull_mode` shows configuration bits [12:11]: 00 pull-up, 01 pull-down, 10 driven output, 11 external source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock for configuration loading |
| rst_n | input | 1 | Synchronous active-low reset of the configuration word |
| cfg_valid | input | 1 | Loads `cfg_word` on the next `clk` rising edge |
| cfg_word | input | 14 | Configuration word, layout in R2 |
| d0 | input | 1 | Output data 0 / operand A |
| d1 | input | 1 | Output data 1 / operand B |
| sel | input | 1 | Selector control in selector mode |
| oce | input | 1 | Output register clock enable |
| ock | input | 1 | Output register clock |
| pad_i | input | 1 | Value seen at the pad |
| ice | input | 1 | Input register clock enable |
| ick | input | 1 | Input register clock |
| eclk | input | 1 | Early clock, routable to either register |
| gsr | input | 1 | Global set/reset, loads the initial values |
| oe_n | input | 1 | Active-low output enable |
| pad_o | output | 1 | Data toward the pad |
| pad_hiz | output | 1 | High-impedance indication |
| in_q | output | 1 | Input register value |
| pull_mode | output | 2 | Pull/drive mode for the pad |

## Verification
On every fabric clock edge the assertions check four things: the configuration word holds without a strobe, the selector output and the XOR function with its inversions reach the pad, and a disabled output reads as high-impedance with data 0. On every register clock edge they check that a register with its enable low holds its value and that a global set/reset leads to the initial value. Only the bench scenarios can show which edge a register captures on under clock inversion, that a rerouted register ignores its own clock, the AND, OR and pass functions with every inversion pair, and the four pull codes after reset.

// File: rtl/iocell_pkg.sv
// Shared types for the configurable I/O cell.
// Assumes the configuration word layout given in the brief; the packed
// struct lists fields from the most significant bit down.
package iocell_pkg;

    localparam int CFG_W = 14;

    typedef enum logic [1:0] {
        FN_PASS = 2'b00,
        FN_AND  = 2'b01,
        FN_OR   = 2'b10,
        FN_XOR  = 2'b11
    } fn_e;

    typedef enum logic [1:0] {
        PULL_UP    = 2'b00,
        PULL_DOWN  = 2'b01,
        PULL_DRIVE = 2'b10,
        PULL_EXT   = 2'b11
    } pull_e;

    typedef struct packed {
        logic  pad_from_reg;   // [13]
        pull_e pull;           // [12:11]
        logic  early_out;      // [10]
        logic  early_in;       // [9]
        logic  init_out;       // [8]
        logic  init_in;        // [7]
        logic  cinv_out;       // [6]
        logic  cinv_in;        // [5]
        logic  inv_b;          // [4]
        logic  inv_a;          // [3]
        fn_e   fn;             // [2:1]
        logic  gate_mode;      // [0]
    } cfg_t;

endpackage

// File: rtl/iocell_cfg.sv
// Static configuration holder for the I/O cell.
// Takes in the word on a rising edge of clk while cfg_valid is high and
// holds it otherwise. A synchronous active-low reset clears it to zero.
module iocell_cfg
    import iocell_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_valid,
    input  logic [CFG_W-1:0] cfg_word,
    output cfg_t             cfg
);

    cfg_t cfg_q;

    // Purpose: load or hold the configuration word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (cfg_valid)
            cfg_q <= cfg_t'(cfg_word);
    end

    assign cfg = cfg_q;

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_valid |=> $stable(cfg_q)) else $error("config changed without strobe"); // R2

endmodule

// File: rtl/iocell_ofunc.sv
// Output path element: a 2:1 selector, or a 2-input gate with an optional
// inversion on each operand. Purely combinational.
module iocell_ofunc
    import iocell_pkg::*;
(
    input  logic gate_mode,
    input  fn_e  fn,
    input  logic inv_a,
    input  logic inv_b,
    input  logic d0,
    input  logic d1,
    input  logic sel,
    output logic y
);

    logic op_a;
    logic op_b;
    logic gate_y;

    // Purpose: apply the per-operand inversion.
    always_comb begin
        op_a = d0 ^ inv_a;
        op_b = d1 ^ inv_b;
    end

    // Purpose: evaluate the selected gate function.
    always_comb begin
        unique case (fn)
            FN_PASS: gate_y = op_a;
            FN_AND:  gate_y = op_a & op_b;
            FN_OR:   gate_y = op_a | op_b;
            FN_XOR:  gate_y = op_a ^ op_b;
            default: gate_y = op_a;
        endcase
    end

    // Purpose: choose between selector and gate behaviour.
    always_comb begin
        if (gate_mode)
            y = gate_y;
        else
            y = sel ? d1 : d0;
    end

endmodule

// File: rtl/iocell_reg.sv
// Single I/O cell register with a selectable clock source, an optional
// clock inversion, a clock enable and a synchronous global set/reset
// that loads a configured initial value. Assumes the clock selection and
// inversion change only while the enable is low.
module iocell_reg (
    input  logic rst_n,
    input  logic base_clk,
    input  logic early_clk,
    input  logic use_early,
    input  logic clk_inv,
    input  logic gsr,
    input  logic init,
    input  logic ce,
    input  logic d,
    output logic q
);

    logic src_clk;
    logic reg_clk;

    // Purpose: pick the clock source and apply the edge inversion.
    always_comb begin
        src_clk = use_early ? early_clk : base_clk;
        reg_clk = src_clk ^ clk_inv;
    end

    // Purpose: storage; global set/reset wins over the clock enable.
    always_ff @(posedge reg_clk) begin
        if (gsr)
            q <= init;
        else if (ce)
            q <= d;
    end

    AST_CE_HOLD: assert property (@(posedge reg_clk) disable iff (!rst_n || gsr)
        !ce |=> $stable(q)) else $error("register moved with enable low"); // R6

    AST_GSR_INIT: assert property (@(posedge reg_clk) disable iff (!rst_n)
        gsr |=> (q == $past(init))) else $error("set/reset missed initial value"); // R9

endmodule

// File: rtl/iocell_top.sv
// Configurable I/O cell: configuration holder, output path element,
// output and input registers, and pad control flags. The pad itself is
// not modelled; the high-impedance state is a flag output.
module iocell_top
    import iocell_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_valid,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic             d0,
    input  logic             d1,
    input  logic             sel,
    input  logic             oce,
    input  logic             ock,
    input  logic             pad_i,
    input  logic             ice,
    input  logic             ick,
    input  logic             eclk,
    input  logic             gsr,
    input  logic             oe_n,
    output logic             pad_o,
    output logic             pad_hiz,
    output logic             in_q,
    output logic [1:0]       pull_mode
);

    cfg_t cfg;
    logic path_y;
    logic out_q;
    logic pad_data;

    iocell_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_valid (cfg_valid),
        .cfg_word  (cfg_word),
        .cfg       (cfg)
    );

    iocell_ofunc u_ofunc (
        .gate_mode (cfg.gate_mode),
        .fn        (cfg.fn),
        .inv_a     (cfg.inv_a),
        .inv_b     (cfg.inv_b),
        .d0        (d0),
        .d1        (d1),
        .sel       (sel),
        .y         (path_y)
    );

    iocell_reg u_oreg (
        .rst_n     (rst_n),
        .base_clk  (ock),
        .early_clk (eclk),
        .use_early (cfg.early_out),
        .clk_inv   (cfg.cinv_out),
        .gsr       (gsr),
        .init      (cfg.init_out),
        .ce        (oce),
        .d         (path_y),
        .q         (out_q)
    );

    iocell_reg u_ireg (
        .rst_n     (rst_n),
        .base_clk  (ick),
        .early_clk (eclk),
        .use_early (cfg.early_in),
        .clk_inv   (cfg.cinv_in),
        .gsr       (gsr),
        .init      (cfg.init_in),
        .ce        (ice),
        .d         (pad_i),
        .q         (in_q)
    );

    // Purpose: choose the pad data source and apply the output enable.
    always_comb begin
        pad_data = cfg.pad_from_reg ? out_q : path_y;
        pad_o    = oe_n ? 1'b0 : pad_data;
        pad_hiz  = oe_n;
    end

    assign pull_mode = cfg.pull;

    AST_MUX_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.gate_mode && !cfg.pad_from_reg && !oe_n) |-> (pad_o == (sel ? d1 : d0)))
        else $error("selector path wrong"); // R3

    AST_XOR_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.gate_mode && cfg.fn == FN_XOR && !cfg.pad_from_reg && !oe_n)
        |-> (pad_o == (d0 ^ d1 ^ cfg.inv_a ^ cfg.inv_b)))
        else $error("xor path wrong"); // R4

    AST_HIZ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (pad_hiz && !pad_o)) else $error("disabled pad not quiet"); // R10

endmodule

// File: tb/tb_iocell_top.sv
module tb_iocell_top;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_valid = 1'b0;
    logic [13:0] cfg_word = '0;
    logic        d0 = 1'b0, d1 = 1'b0, sel = 1'b0;
    logic        oce = 1'b0, ock = 1'b0, pad_i = 1'b0, ice = 1'b0, ick = 1'b0;
    logic        eclk = 1'b0, gsr = 1'b0, oe_n = 1'b0;
    logic        pad_o, pad_hiz, in_q;
    logic [1:0]  pull_mode;

    int n_run = 0;
    int n_fail = 0;

    iocell_top dut (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_word(cfg_word),
        .d0(d0), .d1(d1), .sel(sel), .oce(oce), .ock(ock), .pad_i(pad_i),
        .ice(ice), .ick(ick), .eclk(eclk), .gsr(gsr), .oe_n(oe_n),
        .pad_o(pad_o), .pad_hiz(pad_hiz), .in_q(in_q), .pull_mode(pull_mode)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic load_cfg(input logic [13:0] w);
        @(negedge clk);
        cfg_word  = w;
        cfg_valid = 1'b1;
        @(negedge clk);
        cfg_valid = 1'b0;
        #1;
    endtask

    function automatic logic path_exp(input logic [13:0] w, input logic a0,
                                      input logic a1, input logic s);
        logic a, b;
        if (!w[0]) return s ? a1 : a0;
        a = a0 ^ w[3];
        b = a1 ^ w[4];
        case (w[2:1])
            2'b00:   return a;
            2'b01:   return a & b;
            2'b10:   return a | b;
            default: return a ^ b;
        endcase
    endfunction

    task automatic set_clk(input int which, input logic v);
        case (which)
            0:       ick  = v;
            1:       ock  = v;
            default: eclk = v;
        endcase
    endtask

    task automatic pulse(input int which);
        #2 set_clk(which, 1'b1);
        #3 set_clk(which, 1'b0);
        #3;
    endtask

    initial begin
        #(CLK_P * 150000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [13:0] w;
        void'($urandom(32'd1234));
        // reset phase with set/reset pulses to give the registers known values
        repeat (3) @(negedge clk);
        gsr = 1'b1;
        pulse(0);
        pulse(1);
        gsr = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;

        // R1 reset state
        d0 = 1'b1; d1 = 1'b0; sel = 1'b0; #1;
        chk("R1 pull after reset", pull_mode, 2'b00);
        chk("R1 selector default d0", {1'b0, pad_o}, 2'b01);
        sel = 1'b1; #1;
        chk("R1 selector default d1", {1'b0, pad_o}, 2'b00);
        chk("R1 hiz low", {1'b0, pad_hiz}, 2'b00);
        chk("R1 in_q initial", {1'b0, in_q}, 2'b00);

        // R2 no load without strobe
        @(negedge clk);
        cfg_word = 14'b01 << 11;
        repeat (3) @(negedge clk);
        chk("R2 word ignored without strobe", pull_mode, 2'b00);
        load_cfg(14'b01 << 11);
        chk("R2 word loaded with strobe", pull_mode, 2'b01);

        // R11 every pull code
        for (int p = 0; p < 4; p++) begin
            load_cfg(14'(p) << 11);
            chk("R11 pull code", pull_mode, 2'(p));
        end

        // R4 directed: every function, inversion pair and operand pair
        for (int f = 0; f < 4; f++) begin
            for (int iv = 0; iv < 4; iv++) begin
                w = '0;
                w[0] = 1'b1;
                w[2:1] = 2'(f);
                w[4:3] = 2'(iv);
                load_cfg(w);
                for (int v = 0; v < 4; v++) begin
                    d0 = v[0]; d1 = v[1]; #1;
                    chk("R4 gate function", {1'b0, pad_o}, {1'b0, path_exp(w, d0, d1, sel)});
                end
            end
        end

        // R3/R4/R10 random configurations and inputs
        for (int i = 0; i < 200; i++) begin
            w = 14'($urandom);
            w[13] = 1'b0;
            w[6:5] = 2'b00;
            w[10:9] = 2'b00;
            load_cfg(w);
            for (int k = 0; k < 4; k++) begin
                d0 = 1'($urandom); d1 = 1'($urandom); sel = 1'($urandom);
                oe_n = 1'($urandom);
                #1;
                chk(w[0] ? "R4 random gate" : "R3 random selector", {1'b0, pad_o},
                    {1'b0, oe_n ? 1'b0 : path_exp(w, d0, d1, sel)});
                chk("R10 hiz flag", {1'b0, pad_hiz}, {1'b0, oe_n});
            end
        end
        oe_n = 1'b1; d0 = 1'b1; sel = 1'b0;
        load_cfg('0);
        chk("R10 disabled pad data", {1'b0, pad_o}, 2'b00);
        oe_n = 1'b0; #1;

        // R5 output register path, with set/reset to a known value (R9)
        w = '0; w[13] = 1'b1;
        load_cfg(w);
        d0 = 1'b1; sel = 1'b0; oce = 1'b1;
        gsr = 1'b1; pulse(1); gsr = 1'b0;
        chk("R9 output reg cleared over enable", {1'b0, pad_o}, 2'b00);
        pulse(1);
        chk("R5 output reg capture", {1'b0, pad_o}, 2'b01);
        oce = 1'b0; d0 = 1'b0;
        pulse(1);
        chk("R5 output reg hold", {1'b0, pad_o}, 2'b01);
        oce = 1'b1;
        pulse(1);
        chk("R5 output reg recapture", {1'b0, pad_o}, 2'b00);
        oce = 1'b0;

        // R6 input register
        ice = 1'b1; pad_i = 1'b1;
        pulse(0);
        chk("R6 input capture", {1'b0, in_q}, 2'b01);
        ice = 1'b0; pad_i = 1'b0;
        pulse(0);
        chk("R6 input hold", {1'b0, in_q}, 2'b01);

        // R7 falling-edge input register
        w = '0; w[5] = 1'b1;
        load_cfg(w);
        ice = 1'b1; pad_i = 1'b0;
        #2 ick = 1'b1; #3;
        chk("R7 rising edge ignored", {1'b0, in_q}, 2'b01);
        ick = 1'b0; #3;
        chk("R7 falling edge captures", {1'b0, in_q}, 2'b00);
        ice = 1'b0;

        // R7 falling-edge output register
        w = '0; w[6] = 1'b1; w[13] = 1'b1;
        load_cfg(w);
        d0 = 1'b1; sel = 1'b0; oce = 1'b1;
        #2 ock = 1'b1; #3;
        chk("R7 output rising ignored", {1'b0, pad_o}, 2'b00);
        ock = 1'b0; #3;
        chk("R7 output falling captures", {1'b0, pad_o}, 2'b01);
        oce = 1'b0;

        // R8 early clock routing
        w = '0; w[9] = 1'b1; w[10] = 1'b1; w[13] = 1'b1;
        load_cfg(w);
        ice = 1'b1; pad_i = 1'b1; oce = 1'b1; d0 = 1'b0;
        pulse(0);
        pulse(1);
        chk("R8 own input clock ignored", {1'b0, in_q}, 2'b00);
        chk("R8 own output clock ignored", {1'b0, pad_o}, 2'b01);
        pulse(2);
        chk("R8 early clock input capture", {1'b0, in_q}, 2'b01);
        chk("R8 early clock output capture", {1'b0, pad_o}, 2'b00);
        ice = 1'b0; oce = 1'b0;

        // R9 set/reset loads initial value of 1 over enable
        w = '0; w[7] = 1'b1; w[8] = 1'b1; w[13] = 1'b1;
        load_cfg(w);
        ice = 1'b1; pad_i = 1'b0; oce = 1'b1; d0 = 1'b0; gsr = 1'b1;
        pulse(0);
        pulse(1);
        chk("R9 input set", {1'b0, in_q}, 2'b01);
        chk("R9 output set", {1'b0, pad_o}, 2'b01);
        gsr = 1'b0;
        pulse(0);
        pulse(1);
        chk("R9 input released", {1'b0, in_q}, 2'b00);
        chk("R9 output released", {1'b0, pad_o}, 2'b00);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule